// File: doc/BRIEF.md
# Latched Bidirectional Bus Transceiver

This block couples two parallel buses, side A and side B, through a pair of storage banks: one for traffic moving from A to B and one for traffic moving from B to A. The bus is divided into equal slices (two slices of eight bits by default). Each slice has its own six active-low controls, three for each direction, and each slice works on its own. For each direction the controls are an enable, a latch enable and an output enable. A storage bank passes its input straight through, captures it on a rising control edge, or holds what it captured before.

The block does not model real tri-state pins. Each side's output is a data vector plus a per-bit drive-enable, and the surrounding logic resolves the wire. The control inputs are sampled on a system clock, and a rising edge on a latch enable or an enable is detected against the value from the previous cycle. Data in pass-through mode reaches the far side in the same cycle through combinational logic. If both directions of one slice ask to drive at the same time, the slice raises a per-slice conflict flag and drives neither side.

Top module: `xcvr_bus`

## Requirements
- R1: Slices are independent: controls and data of one slice never change the outputs or stored values of another slice.
- R2: When a direction's enable and latch enable are both low, the bank is transparent: while that direction drives, the output slice equals the input slice in the same cycle.
- R3: If a latch enable is high at a clock edge and was low at the previous edge, the bank stores the input slice present at that edge. From then on the output shows the stored value and no longer follows the input.
- R4: If a direction's enable is high at a clock edge and was low at the previous edge, the bank stores the input slice in the same way as in R3.
- R5: A direction drives only when its enable and its output enable are both low. Otherwise every drive-enable bit of that output slice is 0 and the data slice reads 0. When it drives, all eight drive-enable bits are 1.
- R6: With the enable low and the latch enable high and steady, the stored value does not change when the input changes.
- R7: The B-to-A direction behaves as R2 to R6 describe, using its own three controls and its own bank, with B as input and A as output.
- R8: A capture can happen while outputs are disabled. The stored value appears once the enable and the output enable are both low.
- R9: While the active-low reset is low, all drive-enable bits are 0. Reset clears every bank to zero.
- R10: If both directions of a slice would drive at once, that slice's conflict flag is 1 and neither side of that slice drives. Otherwise the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aIn | input | 16 | Data sampled from side A |
| bIn | input | 16 | Data sampled from side B |
| enAbN | input | 2 | A-to-B enable per slice, active low |
| leAbN | input | 2 | A-to-B latch enable per slice, active low |
| oeAbN | input | 2 | A-to-B output enable per slice, active low |
| enBaN | input | 2 | B-to-A enable per slice, active low |
| leBaN | input | 2 | B-to-A latch enable per slice, active low |
| oeBaN | input | 2 | B-to-A output enable per slice, active low |
| aOut | output | 16 | Data presented toward side A |
| aOe | output | 16 | Per-bit drive-enable for side A |
| bOut | output | 16 | Data presented toward side B |
| bOe | output | 16 | Per-bit drive-enable for side B |
| busFight | output | 2 | Per-slice conflict flag |

## Verification
On every cycle the assertions check that a capture strobe loads the input seen at that edge, that a bank keeps its value when no load occurs, that a transparent driving path copies A to B, that a disabled direction drives no bit, and that a conflict silences both sides. Some properties only the directed scenarios can show. These are the difference between the two edge sources that capture, the hold of a value captured while outputs were disabled, reset clearing the banks, and one slice being unaffected by another's traffic. They also cover the B-to-A mirror. The bench shows these through the values seen at the ports.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int SLICE_W = 8;
  parameter int SLICES  = 2;
  localparam int BUS_W  = SLICE_W * SLICES;

  // strobes handed from a slice's control to its datapath
  typedef struct packed {
    logic loadAb;   // write A-side data into the A-to-B bank
    logic loadBa;   // write B-side data into the B-to-A bank
    logic passAb;   // A-to-B bank is transparent
    logic passBa;   // B-to-A bank is transparent
    logic driveAb;  // present data on side B
    logic driveBa;  // present data on side A
  } xcvr_strobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enAbN,
  input  logic         leAbN,
  input  logic         oeAbN,
  input  logic         enBaN,
  input  logic         leBaN,
  input  logic         oeBaN,
  output xcvr_strobe_t strb,
  output logic         fight
);
  // previous-cycle copies of the edge-sensitive controls; index 0 = AB, 1 = BA
  logic [1:0] enQ, leQ;
  logic [1:0] enNow, leNow, oeNow;
  logic [1:0] rise, pass, wantDrive;

  assign enNow = {enBaN, enAbN};
  assign leNow = {leBaN, leAbN};
  assign oeNow = {oeBaN, oeAbN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= 2'b11;
      leQ <= 2'b11;
    end else begin
      enQ <= enNow;
      leQ <= leNow;
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    assign rise[d]      = (leNow[d] & ~leQ[d]) | (enNow[d] & ~enQ[d]);
    assign pass[d]      = ~enNow[d] & ~leNow[d];
    assign wantDrive[d] = ~enNow[d] & ~oeNow[d] & rstN;
  end

  assign fight = wantDrive[0] & wantDrive[1];

  always_comb begin
    strb.loadAb  = pass[0] | rise[0];
    strb.loadBa  = pass[1] | rise[1];
    strb.passAb  = pass[0];
    strb.passBa  = pass[1];
    strb.driveAb = wantDrive[0] & ~fight;
    strb.driveBa = wantDrive[1] & ~fight;
  end

  // a latch-enable rising edge must always produce a load strobe
  AST_LE_EDGE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (leAbN && !$past(leAbN)) |-> strb.loadAb);  // R3
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W = SLICE_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  xcvr_strobe_t strb,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] aOut,
  output logic [W-1:0] aOe,
  output logic [W-1:0] bOut,
  output logic [W-1:0] bOe
);
  logic [W-1:0] bankAb, bankBa;
  logic [W-1:0] valAb, valBa;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankAb <= '0;
      bankBa <= '0;
    end else begin
      if (strb.loadAb) bankAb <= aIn;
      if (strb.loadBa) bankBa <= bIn;
    end
  end

  assign valAb = strb.passAb ? aIn : bankAb;
  assign valBa = strb.passBa ? bIn : bankBa;

  assign bOe  = {W{strb.driveAb}};
  assign aOe  = {W{strb.driveBa}};
  assign bOut = strb.driveAb ? valAb : '0;
  assign aOut = strb.driveBa ? valBa : '0;

  AST_CAPTURE_AB: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAb |=> bankAb == $past(aIn));  // R3
  AST_CAPTURE_BA: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBa |=> bankBa == $past(bIn));  // R7
  AST_HOLD_AB: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadAb |=> $stable(bankAb));  // R6
  AST_HOLD_BA: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadBa |=> $stable(bankBa));  // R7
endmodule

// File: rtl/xcvr_bus.sv
module xcvr_bus
  import xcvr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [BUS_W-1:0]   aIn,
  input  logic [BUS_W-1:0]   bIn,
  input  logic [SLICES-1:0]  enAbN,
  input  logic [SLICES-1:0]  leAbN,
  input  logic [SLICES-1:0]  oeAbN,
  input  logic [SLICES-1:0]  enBaN,
  input  logic [SLICES-1:0]  leBaN,
  input  logic [SLICES-1:0]  oeBaN,
  output logic [BUS_W-1:0]   aOut,
  output logic [BUS_W-1:0]   aOe,
  output logic [BUS_W-1:0]   bOut,
  output logic [BUS_W-1:0]   bOe,
  output logic [SLICES-1:0]  busFight
);
  localparam int W = SLICE_W;

  for (genvar h = 0; h < SLICES; h++) begin : g_slice
    xcvr_strobe_t strb;

    xcvr_ctrl u_ctrl (
      .clk   (clk),
      .rstN  (rstN),
      .enAbN (enAbN[h]),
      .leAbN (leAbN[h]),
      .oeAbN (oeAbN[h]),
      .enBaN (enBaN[h]),
      .leBaN (leBaN[h]),
      .oeBaN (oeBaN[h]),
      .strb  (strb),
      .fight (busFight[h])
    );

    xcvr_path #(.W(W)) u_path (
      .clk  (clk),
      .rstN (rstN),
      .strb (strb),
      .aIn  (aIn[h*W +: W]),
      .bIn  (bIn[h*W +: W]),
      .aOut (aOut[h*W +: W]),
      .aOe  (aOe[h*W +: W]),
      .bOut (bOut[h*W +: W]),
      .bOe  (bOe[h*W +: W])
    );

    AST_TRANSPARENT_AB: assert property (@(posedge clk) disable iff (!rstN)
      (!enAbN[h] && !leAbN[h] && !oeAbN[h] && (enBaN[h] || oeBaN[h]))
        |-> (bOut[h*W +: W] == aIn[h*W +: W]) && (&bOe[h*W +: W]));  // R2
    AST_DISABLED_B: assert property (@(posedge clk) disable iff (!rstN)
      (enAbN[h] || oeAbN[h]) |-> bOe[h*W +: W] == '0);  // R5
    AST_DISABLED_A: assert property (@(posedge clk) disable iff (!rstN)
      (enBaN[h] || oeBaN[h]) |-> aOe[h*W +: W] == '0);  // R7
    AST_FIGHT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      (!enAbN[h] && !oeAbN[h] && !enBaN[h] && !oeBaN[h]) |-> busFight[h]);  // R10
    AST_FIGHT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      busFight[h] |-> (aOe[h*W +: W] == '0) && (bOe[h*W +: W] == '0));  // R10
  end

  always_comb begin
    if (!rstN) AST_RESET_QUIET: assert (aOe == '0 && bOe == '0);  // R9
  end
endmodule

// File: tb/xcvr_bus_test.sv
module xcvr_bus_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] aIn = '0, bIn = '0;
  logic [1:0]  enAbN = '1, leAbN = '1, oeAbN = '1;
  logic [1:0]  enBaN = '1, leBaN = '1, oeBaN = '1;
  logic [15:0] aOut, aOe, bOut, bOe;
  logic [1:0]  busFight;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  xcvr_bus uut (
    .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
    .enAbN(enAbN), .leAbN(leAbN), .oeAbN(oeAbN),
    .enBaN(enBaN), .leBaN(leBaN), .oeBaN(oeBaN),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe), .busFight(busFight)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic setAb(input int h, input bit en, input bit le, input bit oe);
    enAbN[h] = en; leAbN[h] = le; oeAbN[h] = oe;
  endtask

  task automatic setBa(input int h, input bit en, input bit le, input bit oe);
    enBaN[h] = en; leBaN[h] = le; oeBaN[h] = oe;
  endtask

  task automatic t_reset();
    setAb(0, 0, 0, 0);
    aIn = 16'h00AA;
    settle();
    check("R9 oe low in reset", bOe | aOe, 16'h0000);
    setAb(0, 1, 1, 1);
    tick();
    rstN = 1'b1;
    tick();
    setAb(0, 0, 1, 0);
    settle();
    check("R9 cleared bank", bOut[7:0], 8'h00);
    check("R5 drive all bits", bOe[7:0], 8'hFF);
  endtask

  task automatic t_transparent();
    setAb(0, 0, 0, 0);
    aIn[7:0] = 8'h5A;
    settle();
    check("R2 follow", bOut[7:0], 8'h5A);
    aIn[7:0] = 8'hC3;
    settle();
    check("R2 follow same cycle", bOut[7:0], 8'hC3);
  endtask

  task automatic t_le_capture();
    setAb(0, 0, 0, 0);
    aIn[7:0] = 8'h11;
    tick();
    leAbN[0] = 1'b1;
    aIn[7:0] = 8'h22;
    tick();
    aIn[7:0] = 8'h33;
    settle();
    check("R3 captured at edge", bOut[7:0], 8'h22);
    tick();
    aIn[7:0] = 8'h44;
    tick();
    check("R6 hold", bOut[7:0], 8'h22);
  endtask

  task automatic t_en_capture();
    setAb(0, 0, 1, 0);
    aIn[7:0] = 8'h55;
    tick();
    enAbN[0] = 1'b1;
    aIn[7:0] = 8'h56;
    settle();
    check("R5 enable high", bOe[7:0], 8'h00);
    check("R5 data zero", bOut[7:0], 8'h00);
    tick();
    enAbN[0] = 1'b0;
    aIn[7:0] = 8'h66;
    settle();
    check("R4 enable edge capture", bOut[7:0], 8'h56);
    tick();
    check("R4 kept", bOut[7:0], 8'h56);
  endtask

  task automatic t_capture_disabled();
    setAb(0, 0, 0, 1);
    aIn[7:0] = 8'h77;
    tick();
    check("R5 oe high", bOe[7:0], 8'h00);
    leAbN[0] = 1'b1;
    aIn[7:0] = 8'h78;
    tick();
    check("R8 still quiet", bOe[7:0], 8'h00);
    oeAbN[0] = 1'b0;
    aIn[7:0] = 8'h79;
    settle();
    check("R8 stored shown", bOut[7:0], 8'h78);
  endtask

  task automatic t_ba_mirror();
    setAb(0, 1, 1, 1);
    setBa(1, 0, 0, 0);
    bIn[15:8] = 8'h9C;
    settle();
    check("R7 transparent", aOut[15:8], 8'h9C);
    check("R7 drive", aOe[15:8], 8'hFF);
    tick();
    leBaN[1] = 1'b1;
    bIn[15:8] = 8'hA5;
    tick();
    bIn[15:8] = 8'h00;
    tick();
    check("R7 capture hold", aOut[15:8], 8'hA5);
    setBa(1, 1, 1, 1);
    settle();
    check("R7 disable", aOe[15:8], 8'h00);
  endtask

  task automatic t_contention();
    setAb(0, 0, 1, 0);
    setBa(0, 0, 1, 0);
    settle();
    check("R10 flag", {14'd0, busFight}, 16'h0001);
    check("R10 quiet", {aOe[7:0], bOe[7:0]}, 16'h0000);
    setBa(0, 1, 1, 1);
    settle();
    check("R10 flag clear", {14'd0, busFight}, 16'h0000);
    check("R10 B drives again", bOe[7:0], 8'hFF);
    tick();
  endtask

  task automatic t_halves();
    setAb(1, 0, 0, 0);
    aIn[15:8] = 8'hE1;
    tick();
    leAbN[1] = 1'b1;
    tick();
    setAb(0, 0, 0, 0);
    aIn = 16'h00F0;
    tick();
    check("R1 slice1 held", bOut[15:8], 8'hE1);
    check("R1 slice0 follows", bOut[7:0], 8'hF0);
    aIn = 16'h330F;
    settle();
    check("R1 slice0 new", bOut[7:0], 8'h0F);
    check("R1 slice1 unchanged", bOut[15:8], 8'hE1);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_transparent();
    t_le_capture();
    t_en_capture();
    t_capture_disabled();
    t_ba_mirror();
    t_contention();
    t_halves();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule